// File: doc/BRIEF.md
# Unit-Selectable Watchdog Timer with Reload Sources

This block is a watchdog timer that software programs through a small set of indexed configuration registers. A count value is loaded by writing its bytes. While the count is non-zero the watchdog is armed. It then decrements on each externally supplied prescaled tick of the selected unit, either a seconds tick or a minutes tick. When the count passes from one to zero, the block raises a sticky timeout flag. Depending on the configuration, it also drives a level reset output and single-cycle keyboard-reset and power-good pulses.

Instead of rewriting the count, system activity can restart the timer. Four event inputs can each be enabled separately: a game-port read, a keyboard event, a mouse event and a consumer-infrared data write. Any enabled event reloads the count from the last programmed value. The infrared source takes effect only after a fixed delay of `CIR_DELAY` clock cycles. Writing a zero count disarms the watchdog. A force bit in the control register produces an immediate timeout.

Top module: `wdog_unit_timer`

## Requirements
- R1: After reset, all four registers read 0x00, the count is zero (disarmed), and `wdt_rst_o`, `kbrst_o` and `pwrok_o` are low.
- R2: Register indices and fields are fixed as follows. Control 0x71: bit 7 infrared reload enable, bit 6 mouse reload enable, bit 5 keyboard reload enable, bit 4 game-port reload enable, bit 1 force (reads 0), bit 0 timeout flag. Config 0x72: bit 7 unit (1 = seconds, 0 = minutes), bit 6 keyboard-reset enable, bit 5 reset-output enable, bit 4 power-good pulse enable, bits 3:0 interrupt routing, driven on `irq_route_o`. Count low byte 0x73, count high byte 0x74. Both count bytes read back the programmed value. Any other index reads 0x00.
- R3: An armed count decrements only on a tick of the selected unit. A tick of the other unit has no effect.
- R4: On the tick that takes the count from 1 to 0, the timeout flag is set in the following cycle. `wdt_rst_o` equals the flag AND config bit 5.
- R5: Once set, the timeout flag stays set until the control register is written with exactly 0x00. Other control writes leave it set.
- R6: A one-cycle pulse on an enabled game-port, keyboard or mouse input reloads an armed count from the programmed value. Pulses on disabled inputs have no effect. A reload does not clear the timeout flag.
- R7: An enabled infrared write reloads the count `CIR_DELAY` cycles after the pulse, not at once. A timeout that occurs before then still fires.
- R8: Writing a count byte loads the counter at once. A resulting count of zero disarms the watchdog, and no timeout follows however many ticks arrive.
- R9: Writing the control register with bit 1 set causes a timeout in the next cycle, whatever the count.
- R10: On each timeout, `kbrst_o` pulses high for one cycle if config bit 6 is set, and `pwrok_o` pulses high for one cycle if config bit 4 is set.
- R11: With the default 16-bit count, the high byte extends the count: a count of 0x0100 needs exactly 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| tick_sec | input | 1 | One-cycle seconds tick |
| tick_min | input | 1 | One-cycle minutes tick |
| gp_read | input | 1 | Game-port read event |
| cir_write | input | 1 | Infrared data write event |
| kbd_evt | input | 1 | Keyboard event |
| mouse_evt | input | 1 | Mouse event |
| wdt_rst_o | output | 1 | Reset output level |
| kbrst_o | output | 1 | Keyboard-reset pulse |
| pwrok_o | output | 1 | Power-good pulse |
| irq_route_o | output | 4 | Interrupt routing field |

## Verification
The hardest situation to reach is a race between a delayed infrared reload and the final decrement.

In the first case, the bench takes the count down to one and pulses the infrared input. It then ticks in the very next cycle, so the timeout must fire even though a reload is pending. In the second case, it waits out the full delay before ticking, so the count must survive one more tick. The late reload that arrives after the early timeout must not re-arm the disarmed count, and the bench checks this too.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] IDX_CTRL   = 8'h71;
  localparam logic [7:0] IDX_CFG    = 8'h72;
  localparam logic [7:0] IDX_CNT_LO = 8'h73;
  localparam logic [7:0] IDX_CNT_HI = 8'h74;

  // reload enable positions within the stored enable nibble (ctrl[7:4])
  localparam int SRC_GP    = 0;
  localparam int SRC_KBD   = 1;
  localparam int SRC_MOUSE = 2;
  localparam int SRC_CIR   = 3;

  typedef struct packed {
    logic       unit_sec;
    logic       kbrst_en;
    logic       rst_en;
    logic       pwrok_en;
    logic [3:0] route;
  } wdog_cfg_t;

  // choose the tick that matches the configured unit
  function automatic logic unit_tick(input logic sec_unit, input logic ts, input logic tm);
    return sec_unit ? ts : tm;
  endfunction

  // control register image as seen on a read
  function automatic logic [7:0] ctrl_image(input logic [3:0] en, input logic flag);
    return {en, 3'b000, flag};
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             expire,
  output logic [7:0]       rdata,
  output logic [3:0]       src_en,
  output wdog_cfg_t        cfg,
  output logic [CNT_W-1:0] preset,
  output logic             load_stb,
  output logic [CNT_W-1:0] load_val,
  output logic             force_stb,
  output logic             flag
);
  localparam bit HAS_HI = (CNT_W > 8);
  localparam logic [CNT_W-1:0] LO_MASK = CNT_W'(8'hFF);

  logic [3:0]       en_q;
  wdog_cfg_t        cfg_q;
  logic [CNT_W-1:0] preset_q;
  logic             flag_q;
  logic             wr_ctrl, wr_cfg, wr_lo, wr_hi, clr_flag;
  logic [7:0]       rd_hi;

  assign wr_ctrl   = we && (addr == IDX_CTRL);
  assign wr_cfg    = we && (addr == IDX_CFG);
  assign wr_lo     = we && (addr == IDX_CNT_LO);
  assign wr_hi     = we && (addr == IDX_CNT_HI) && HAS_HI;
  assign clr_flag  = wr_ctrl && (wdata == 8'h00);
  assign force_stb = wr_ctrl && wdata[1];

  always_comb begin
    load_stb = wr_lo || wr_hi;
    load_val = preset_q;
    if (wr_lo)
      load_val = (preset_q & ~LO_MASK) | CNT_W'(wdata);
    else if (wr_hi)
      load_val = (preset_q & ~(LO_MASK << 8)) | (CNT_W'(wdata) << 8);
  end

  generate
    if (HAS_HI) begin : g_hi
      assign rd_hi = 8'(preset_q >> 8);
    end else begin : g_nohi
      assign rd_hi = 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      cfg_q    <= '0;
      preset_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl)  en_q     <= wdata[7:4];
      if (wr_cfg)   cfg_q    <= wdata;
      if (load_stb) preset_q <= load_val;
      if (expire)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      IDX_CTRL:   rdata = ctrl_image(en_q, flag_q);
      IDX_CFG:    rdata = cfg_q;
      IDX_CNT_LO: rdata = preset_q[7:0];
      IDX_CNT_HI: rdata = rd_hi;
      default:    rdata = 8'h00;
    endcase
  end

  assign src_en = en_q;
  assign cfg    = cfg_q;
  assign preset = preset_q;
  assign flag   = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q); // R4
endmodule

// File: rtl/wdog_reload.sv
module wdog_reload
  import wdog_pkg::*;
#(
  parameter int CIR_DELAY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] src_en,
  input  logic       gp_read,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  input  logic       cir_write,
  output logic       reload
);
  localparam int DW = $clog2(CIR_DELAY + 1);

  logic [DW-1:0] pend_q;
  logic [2:0]    direct_raw;
  logic [2:0]    direct_hit;
  logic          cir_fire;

  assign direct_raw[SRC_GP]    = gp_read;
  assign direct_raw[SRC_KBD]   = kbd_evt;
  assign direct_raw[SRC_MOUSE] = mouse_evt;

  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_src
      assign direct_hit[gi] = direct_raw[gi] && src_en[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= '0;
    else if (cir_write && src_en[SRC_CIR])
      pend_q <= DW'(CIR_DELAY);
    else if (pend_q != '0)
      pend_q <= pend_q - DW'(1);
  end

  assign cir_fire = src_en[SRC_CIR] && (pend_q == DW'(1));
  assign reload   = (|direct_hit) || cir_fire;

  AST_CIR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q <= DW'(CIR_DELAY))); // R7
  AST_CIR_FIRE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cir_write && src_en[SRC_CIR]) |=> !cir_fire || (CIR_DELAY == 1)); // R7
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preset,
  input  logic             reload,
  input  logic             force_stb,
  input  logic             tick_hit,
  output logic             expire,
  output logic             armed
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reload_eff, last_tick;

  assign armed      = (cnt_q != '0);
  assign reload_eff = reload && armed;
  assign last_tick  = tick_hit && (cnt_q == CNT_W'(1));
  assign expire     = force_stb || (!load_stb && !reload_eff && last_tick);

  always_comb begin
    if (load_stb)               cnt_d = load_val;
    else if (force_stb)         cnt_d = '0;
    else if (reload_eff)        cnt_d = preset;
    else if (tick_hit && armed) cnt_d = cnt_q - CNT_W'(1);
    else                        cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !force_stb && !reload && !tick_hit) |=> $stable(cnt_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !force_stb) |-> !expire); // R8
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_eff && !load_stb && !force_stb) |=> (cnt_q == $past(preset))); // R6
  AST_ZERO_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load_stb) |=> !armed); // R4
endmodule

// File: rtl/wdog_unit_timer.sv
module wdog_unit_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int CIR_DELAY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tick_sec,
  input  logic       tick_min,
  input  logic       gp_read,
  input  logic       cir_write,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_rst_o,
  output logic       kbrst_o,
  output logic       pwrok_o,
  output logic [3:0] irq_route_o
);
  logic [3:0]       src_en;
  wdog_cfg_t        cfg;
  logic [CNT_W-1:0] preset, load_val;
  logic             load_stb, force_stb, flag;
  logic             reload, expire, armed, tick_hit;
  logic             kbrst_q, pwrok_q;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .expire(expire), .rdata(cfg_rdata), .src_en(src_en), .cfg(cfg),
    .preset(preset), .load_stb(load_stb), .load_val(load_val),
    .force_stb(force_stb), .flag(flag)
  );

  wdog_reload #(.CIR_DELAY(CIR_DELAY)) u_reload (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .gp_read(gp_read),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .cir_write(cir_write),
    .reload(reload)
  );

  assign tick_hit = unit_tick(cfg.unit_sec, tick_sec, tick_min);

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
    .preset(preset), .reload(reload), .force_stb(force_stb),
    .tick_hit(tick_hit), .expire(expire), .armed(armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbrst_q <= 1'b0;
      pwrok_q <= 1'b0;
    end else begin
      kbrst_q <= expire && cfg.kbrst_en;
      pwrok_q <= expire && cfg.pwrok_en;
    end
  end

  assign kbrst_o     = kbrst_q;
  assign pwrok_o     = pwrok_q;
  assign wdt_rst_o   = flag && cfg.rst_en;
  assign irq_route_o = cfg.route;

  AST_KBRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    kbrst_o |-> $past(expire)); // R10
  AST_PWROK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwrok_o |-> $past(expire)); // R10
  AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> flag); // R4
  AST_FORCE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    force_stb |=> (flag && !armed)); // R9
endmodule

// File: tb/test_wdog_unit_timer.sv
`timescale 1ns/1ps
module test_wdog_unit_timer;
  localparam int DLY = 8;
  localparam logic [7:0] A_CTRL = 8'h71, A_CFG = 8'h72, A_LO = 8'h73, A_HI = 8'h74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic tick_sec = 0, tick_min = 0, gp_read = 0, cir_write = 0, kbd_evt = 0, mouse_evt = 0;
  logic wdt_rst_o, kbrst_o, pwrok_o;
  logic [3:0] irq_route_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_unit_timer #(.CNT_W(16), .CIR_DELAY(DLY)) i_wdog_unit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_sec(tick_sec),
    .tick_min(tick_min), .gp_read(gp_read), .cir_write(cir_write),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .wdt_rst_o(wdt_rst_o),
    .kbrst_o(kbrst_o), .pwrok_o(pwrok_o), .irq_route_o(irq_route_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a; #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic tk(input bit sec);
    @(negedge clk); if (sec) tick_sec = 1; else tick_min = 1;
    @(negedge clk); tick_sec = 0; tick_min = 0;
  endtask

  // 0 gp, 1 kbd, 2 mouse, 3 cir
  task automatic ev(input int which);
    @(negedge clk);
    case (which) 0: gp_read = 1; 1: kbd_evt = 1; 2: mouse_evt = 1; default: cir_write = 1; endcase
    @(negedge clk); gp_read = 0; kbd_evt = 0; mouse_evt = 0; cir_write = 0;
  endtask

  task automatic clear_all();
    wr(A_CTRL, 8'h00); wr(A_LO, 8'h00); wr(A_HI, 8'h00);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 8'h00); rd_chk("R1 cfg", A_CFG, 8'h00);
    rd_chk("R1 lo", A_LO, 8'h00);     rd_chk("R1 hi", A_HI, 8'h00);
    chk("R1 outputs", {wdt_rst_o, kbrst_o, pwrok_o}, 0);
  endtask

  task automatic t_regs();
    wr(A_CFG, 8'hA5); rd_chk("R2 cfg readback", A_CFG, 8'hA5);
    chk("R2 route", irq_route_o, 4'h5);
    wr(A_CTRL, 8'hF2);   // force on an idle count also fires (R9)
    rd_chk("R2 ctrl image, force reads 0", A_CTRL, 8'hF1);
    chk("R9 force on idle count", wdt_rst_o, 1);
    rd_chk("R2 unused index", 8'h75, 8'h00);
    wr(A_CTRL, 8'h00); wr(A_CFG, 8'h00);
  endtask

  task automatic t_units();
    wr(A_CFG, 8'hA0); wr(A_LO, 8'h03);
    tk(0); tk(0); chk("R3 minute ticks ignored in seconds unit", wdt_rst_o, 0);
    tk(1); tk(1); chk("R3 two of three seconds", wdt_rst_o, 0);
    tk(1); chk("R4 timeout on 1->0", wdt_rst_o, 1);
    rd_chk("R4 flag bit", A_CTRL, 8'h01);
    wr(A_CTRL, 8'h10); rd_chk("R5 nonzero write keeps flag", A_CTRL, 8'h11);
    wr(A_CTRL, 8'h00); chk("R5 zero write clears", wdt_rst_o, 0);
    wr(A_CFG, 8'h20); wr(A_LO, 8'h02);
    for (int i = 0; i < 5; i++) tk(1);
    tk(0); chk("R3 seconds ignored in minutes unit", wdt_rst_o, 0);
    tk(0); chk("R3 minutes timeout", wdt_rst_o, 1);
    clear_all();
  endtask

  task automatic t_direct_reload();
    wr(A_CFG, 8'hA0); wr(A_CTRL, 8'h10); wr(A_LO, 8'h03);
    tk(1); tk(1); ev(0); tk(1); tk(1);
    chk("R6 game-port reload", wdt_rst_o, 0);
    ev(1); ev(2); ev(3);
    for (int i = 0; i < DLY + 2; i++) @(negedge clk);
    tk(1); chk("R6 disabled sources ignored", wdt_rst_o, 1);
    wr(A_LO, 8'h05); ev(0);
    rd_chk("R6 reload keeps flag", A_CTRL, 8'h11);
    wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h40); wr(A_LO, 8'h02);
    tk(1); ev(2); tk(1); chk("R6 mouse reload", wdt_rst_o, 0);
    tk(1); chk("R6 mouse then expiry", wdt_rst_o, 1);
    wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h20); wr(A_LO, 8'h02);
    tk(1); ev(1); tk(1); chk("R6 keyboard reload", wdt_rst_o, 0);
    clear_all();
  endtask

  task automatic t_cir();
    wr(A_CFG, 8'hA0); wr(A_CTRL, 8'h80); wr(A_LO, 8'h02);
    tk(1); ev(3); tk(1);
    chk("R7 timeout before delayed reload", wdt_rst_o, 1);
    for (int i = 0; i < DLY + 2; i++) @(negedge clk);
    wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h80);
    tk(1); tk(1); chk("R7 late reload did not re-arm", wdt_rst_o, 0);
    wr(A_LO, 8'h02); tk(1); ev(3);
    for (int i = 0; i < DLY + 2; i++) @(negedge clk);
    tk(1); chk("R7 reload after delay", wdt_rst_o, 0);
    tk(1); chk("R7 expiry after reload", wdt_rst_o, 1);
    clear_all();
  endtask

  task automatic t_zero();
    wr(A_CFG, 8'hA0); wr(A_LO, 8'h02); wr(A_LO, 8'h00);
    for (int i = 0; i < 4; i++) tk(1);
    chk("R8 zero count disarms", wdt_rst_o, 0);
    rd_chk("R8 readback zero", A_LO, 8'h00);
  endtask

  task automatic t_pulses();
    wr(A_CFG, 8'h40);
    @(negedge clk); cfg_we = 1; cfg_addr = A_CTRL; cfg_wdata = 8'h02;
    @(negedge clk); cfg_we = 0;
    chk("R10 kbrst pulse", kbrst_o, 1); chk("R10 no pwrok", pwrok_o, 0);
    chk("R4 rst disabled", wdt_rst_o, 0);
    @(negedge clk); chk("R10 kbrst one cycle", kbrst_o, 0);
    wr(A_CTRL, 8'h00); wr(A_CFG, 8'h90);
    @(negedge clk); cfg_we = 1; cfg_addr = A_CTRL; cfg_wdata = 8'h02;
    @(negedge clk); cfg_we = 0;
    chk("R10 pwrok pulse", pwrok_o, 1); chk("R10 no kbrst", kbrst_o, 0);
    @(negedge clk); chk("R10 pwrok one cycle", pwrok_o, 0);
    clear_all();
  endtask

  task automatic t_wide();
    wr(A_CFG, 8'hA0); wr(A_HI, 8'h01); wr(A_LO, 8'h00);
    rd_chk("R11 hi readback", A_HI, 8'h01); rd_chk("R11 lo readback", A_LO, 8'h00);
    for (int i = 0; i < 255; i++) tk(1);
    chk("R11 255 ticks", wdt_rst_o, 0);
    tk(1); chk("R11 256th tick", wdt_rst_o, 1);
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_regs(); t_units(); t_direct_reload();
    t_cir(); t_zero(); t_pulses(); t_wide();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule